// File: doc/BRIEF.md
# Flow-Through Burst Synchronous Static Memory

This block models a synchronous static memory with a flow-through read path. Its words are 18 bits wide and split into two 9-bit byte lanes. All controls except the output enable are captured on the rising clock edge.

A cycle opens in one of two ways, and the two have different precedence:

- **Processor strobe.** It always starts a read.
- **Controller strobe.** It can start a read or a write.

Once a cycle is open, a burst-advance input steps the two low address bits through a 4-beat sequence. A static order input selects between XOR (interleaved) order and modulo-4 (linear) order. Read data comes straight out of the array after the registered address. It is therefore valid in the same cycle that follows the capturing edge.

Instead of a bidirectional data pin, the block has separate data-in and data-out ports and a drive-enable output. The drive enable shows exactly when a real device would drive the shared bus. A surrounding model or bench can use it to check bus-turnaround rules. Three chip enables are provided: an active-low main enable, an active-low second enable and an active-high third enable. Together they allow depth expansion. The array depth is set by the address-width parameter.

Top module: `fbsram`

## Requirements
- R1: After a synchronous reset the drive enable is low until a read cycle has been opened.
- R2: A processor start is an edge with `cpu_stb_n` low, `en_main_n` low, `en_low_n` low and `en_high` high. It loads `addr_i` and is always a read: the write enables and `adv_n` are ignored on that edge. The word at that address is on `dout` in the cycle after the edge.
- R3: When `en_main_n` is high, a low `cpu_stb_n` is treated as if the processor strobe were high. With `ctl_stb_n` high, such an edge is an ordinary continuation edge.
- R4: A controller start is an edge with `ctl_stb_n` low and no processor start. With all three enables active, it loads `addr_i` and samples the write enables on that same edge.
- R5: A deselect is an edge where a strobe acts but an enable fails. This covers a failing second or third enable on a processor start, and any failing enable on a controller start. A deselect turns the drive enable off. Later edges with both strobes inactive change nothing until a new start.
- R6: An edge with both strobes inactive inside an open cycle is a continuation. With `adv_n` low the next burst address is used; with `adv_n` high the current address is reused. Write enables sampled on that edge write `din` to the address used.
- R7: With `order_il` high, the low two address bits equal the start value XOR the beat count (0,1,2,3, wrapping after 3). For example, a start at 01 gives 01,00,11,10,01.
- R8: With `order_il` low, the low two address bits equal the start value plus the beat count modulo 4. For example, a start at 01 gives 01,10,11,00. The upper address bits never change during a burst.
- R9: `wr_all_n` low writes all 18 bits, whatever `wr_byte_n` and `lane_n` say.
- R10: With `wr_all_n` high and `wr_byte_n` low, lane i is written when `lane_n[i]` is low. Lane 0 is bits 8:0 and lane 1 is bits 17:9. If `wr_byte_n` is high, or both `lane_n` bits are high, the cycle is a read.
- R11: Any edge that samples a write turns the drive enable off in the following cycle, even with `oe_n` low.
- R12: The drive enable is high only while `oe_n` is low and the last edge was a read in an open cycle. `oe_n` acts without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW | External word address |
| cpu_stb_n | input | 1 | Processor address strobe, active low, read-only start |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| en_main_n | input | 1 | Main chip enable, active low, gates the processor strobe |
| en_low_n | input | 1 | Second chip enable, active low |
| en_high | input | 1 | Third chip enable, active high |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Burst order: 1 selects XOR order, 0 selects linear order |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 2 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 18 | Write data |
| dout | output | 18 | Read data, flow-through from the registered address |
| dout_en | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach from the ports is a write that happens partway through a burst that a processor strobe opened. The opening edge must show that its write enables are ignored. The next edge must then advance and write to the computed burst address, which only later read-back reveals. The stimulus opens a read with the global write already asserted and a decoy data word on `din`. It then advances once with the write held, suspends with the write released to read the stepped address back, and finally toggles `oe_n` between clock edges. A second hard case is a low processor strobe while the main enable is high. The bench drives it in the middle of an open read, with a different address on `addr_i`, and expects the same word to stay on `dout`.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int BYTE_LANES = 2;
  localparam int LANE_BITS  = 9;
  localparam int WORD_BITS  = BYTE_LANES * LANE_BITS;

  typedef struct packed {
    logic                  load;
    logic                  desel;
    logic                  cont;
    logic                  step;
    logic [BYTE_LANES-1:0] we;
  } fbs_cmd_t;

  // Lane write mask from the three write controls.
  function automatic logic [BYTE_LANES-1:0] lane_mask(input logic all_n,
                                                      input logic byte_n,
                                                      input logic [BYTE_LANES-1:0] ln);
    if (!all_n)       return '1;
    else if (!byte_n) return ~ln;
    else              return '0;
  endfunction
endpackage

// File: rtl/fbs_decode.sv
module fbs_decode
  import fbs_pkg::*;
(
  input  logic                  cpu_stb_n,
  input  logic                  ctl_stb_n,
  input  logic                  en_main_n,
  input  logic                  en_low_n,
  input  logic                  en_high,
  input  logic                  adv_n,
  input  logic                  wr_all_n,
  input  logic                  wr_byte_n,
  input  logic [BYTE_LANES-1:0] lane_n,
  input  logic                  live,
  output fbs_cmd_t              cmd
);
  logic cpu_go, ctl_go, strobe, en_ok;
  logic [BYTE_LANES-1:0] mask;

  always_comb begin
    cpu_go = !cpu_stb_n && !en_main_n;
    ctl_go = !cpu_go && !ctl_stb_n;
    strobe = cpu_go || ctl_go;
    en_ok  = !en_main_n && !en_low_n && en_high;
    mask   = lane_mask(wr_all_n, wr_byte_n, lane_n);

    cmd.load  = strobe && en_ok;
    cmd.desel = strobe && !en_ok;
    cmd.cont  = !strobe && live;
    cmd.step  = cmd.cont && !adv_n;
    cmd.we    = ((ctl_go && cmd.load) || cmd.cont) ? mask : '0;
  end
endmodule

// File: rtl/fbs_burst.sv
module fbs_burst
  import fbs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  fbs_cmd_t      cmd,
  input  logic          order_il,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cyc_addr,
  output logic          live
);
  localparam int BEAT_W = 2;

  logic [BEAT_W-1:0] base_q, cnt_q, cnt_nx, lo_nx;

  always_comb begin
    cnt_nx = cnt_q + 1'b1;
    lo_nx  = order_il ? (base_q ^ cnt_nx) : (base_q + cnt_nx);
    if (cmd.load)      cyc_addr = addr_i;
    else if (cmd.step) cyc_addr = {cur_addr[AW-1:BEAT_W], lo_nx};
    else               cyc_addr = cur_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      live     <= 1'b0;
    end else if (cmd.load) begin
      cur_addr <= addr_i;
      base_q   <= addr_i[BEAT_W-1:0];
      cnt_q    <= '0;
      live     <= 1'b1;
    end else if (cmd.desel) begin
      live     <= 1'b0;
    end else if (cmd.step) begin
      cur_addr <= cyc_addr;
      cnt_q    <= cnt_nx;
    end
  end
endmodule

// File: rtl/fbs_array.sv
module fbs_array
  import fbs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                  clk,
  input  logic [BYTE_LANES-1:0] we,
  input  logic [AW-1:0]         waddr,
  input  logic [WORD_BITS-1:0]  wdata,
  input  logic [AW-1:0]         raddr,
  output logic [WORD_BITS-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < BYTE_LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_BITS +: LANE_BITS];
    end
    assign rdata[g*LANE_BITS +: LANE_BITS] = mem[raddr];
  end
endmodule

// File: rtl/fbsram.sv
module fbsram
  import fbs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         addr_i,
  input  logic                  cpu_stb_n,
  input  logic                  ctl_stb_n,
  input  logic                  en_main_n,
  input  logic                  en_low_n,
  input  logic                  en_high,
  input  logic                  adv_n,
  input  logic                  order_il,
  input  logic                  wr_all_n,
  input  logic                  wr_byte_n,
  input  logic [BYTE_LANES-1:0] lane_n,
  input  logic                  oe_n,
  input  logic [WORD_BITS-1:0]  din,
  output logic [WORD_BITS-1:0]  dout,
  output logic                  dout_en
);
  fbs_cmd_t      cmd;
  logic [AW-1:0] cur_addr, cyc_addr;
  logic          live, rd_q;

  fbs_decode u_dec (
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .en_main_n(en_main_n),
    .en_low_n(en_low_n), .en_high(en_high), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .live(live), .cmd(cmd)
  );

  fbs_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst(rst), .cmd(cmd), .order_il(order_il), .addr_i(addr_i),
    .cur_addr(cur_addr), .cyc_addr(cyc_addr), .live(live)
  );

  fbs_array #(.AW(AW)) u_arr (
    .clk(clk), .we(cmd.we), .waddr(cyc_addr), .wdata(din),
    .raddr(cur_addr), .rdata(dout)
  );

  // Read/write state of the last edge inside an open cycle.
  always_ff @(posedge clk) begin
    if (rst)                        rd_q <= 1'b0;
    else if (cmd.load || cmd.cont)  rd_q <= (cmd.we == '0);
    else if (cmd.desel)             rd_q <= 1'b0;
  end

  assign dout_en = rd_q && live && !oe_n;
endmodule

// File: rtl/fbsram_chk.sv
module fbsram_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_i,
  input logic          cpu_stb_n,
  input logic          ctl_stb_n,
  input logic          en_main_n,
  input logic          en_low_n,
  input logic          en_high,
  input logic          adv_n,
  input logic          wr_all_n,
  input logic          wr_byte_n,
  input logic [1:0]    lane_n,
  input logic          oe_n,
  input logic          dout_en,
  input logic          live,
  input logic          rd_q,
  input logic [AW-1:0] cur_addr
);
  p_drive_needs_oe_r12: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> !oe_n);

  p_cpu_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stb_n && !en_main_n && !en_low_n && en_high)
      |=> (cur_addr == $past(addr_i)) && rd_q);

  p_master_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stb_n && en_main_n && ctl_stb_n && adv_n) |=> $stable(cur_addr));

  p_deselect_r5: assert property (@(posedge clk) disable iff (rst)
    ((!cpu_stb_n && !en_main_n && (en_low_n || !en_high)) ||
     (!ctl_stb_n && (cpu_stb_n || en_main_n) && (en_main_n || en_low_n || !en_high)))
      |=> !live && !dout_en);

  p_suspend_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_stb_n && ctl_stb_n && adv_n) |=> $stable(cur_addr));

  p_write_blocks_drive_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_stb_n && ctl_stb_n && live &&
     (!wr_all_n || (!wr_byte_n && lane_n != 2'b11))) |=> !dout_en);
endmodule

bind fbsram fbsram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .addr_i(addr_i), .cpu_stb_n(cpu_stb_n),
  .ctl_stb_n(ctl_stb_n), .en_main_n(en_main_n), .en_low_n(en_low_n),
  .en_high(en_high), .adv_n(adv_n), .wr_all_n(wr_all_n),
  .wr_byte_n(wr_byte_n), .lane_n(lane_n), .oe_n(oe_n), .dout_en(dout_en),
  .live(live), .rd_q(rd_q), .cur_addr(cur_addr)
);

// File: tb/fbsram_bench.sv
`timescale 1ns/1ps
module fbsram_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_i;
  logic          cpu_stb_n, ctl_stb_n, en_main_n, en_low_n, en_high, adv_n;
  logic          order_il, wr_all_n, wr_byte_n, oe_n;
  logic [1:0]    lane_n;
  logic [17:0]   din, dout;
  logic          dout_en;
  int            total = 0;
  int            bad = 0;

  always #2 clk = ~clk;

  fbsram #(.AW(AW)) u_fbsram (
    .clk(clk), .rst(rst), .addr_i(addr_i), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .en_main_n(en_main_n), .en_low_n(en_low_n),
    .en_high(en_high), .adv_n(adv_n), .order_il(order_il),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [17:0] pat(input logic [AW-1:0] a);
    return {a[8:0] ^ 9'h0A5, a[8:0] + 9'h033};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
    en_main_n = 1'b0; en_low_n = 1'b0; en_high = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_n = 2'b11;
  endtask

  task automatic chk_en(input string req, input logic exp);
    total++;
    if (dout_en !== exp) begin
      bad++;
      $display("FAIL %s: dout_en=%0b expected %0b", req, dout_en, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [17:0] exp);
    total++;
    if (dout_en !== 1'b1 || dout !== exp) begin
      bad++;
      $display("FAIL %s: en=%0b dout=%05h expected en=1 dout=%05h", req, dout_en, dout, exp);
    end
  endtask

  task automatic ctl_write(input logic [AW-1:0] a, input logic [17:0] d);
    idle(); ctl_stb_n = 1'b0; addr_i = a; wr_all_n = 1'b0; din = d;
    tick();
    idle();
  endtask

  task automatic ctl_read(input logic [AW-1:0] a);
    idle(); ctl_stb_n = 1'b0; addr_i = a;
    tick();
    idle();
  endtask

  task automatic cpu_read(input logic [AW-1:0] a);
    idle(); cpu_stb_n = 1'b0; addr_i = a;
    tick();
    idle();
  endtask

  task automatic t_reset();
    chk_en("R1 reset", 1'b0);
  endtask

  task automatic t_prefill();
    for (int i = 0; i < 8; i++) begin
      ctl_write(AW'(10'h020 + i), pat(AW'(10'h020 + i)));
      chk_en("R11 write edge", 1'b0);
      ctl_write(AW'(10'h040 + i), pat(AW'(10'h040 + i)));
    end
    ctl_read(10'h026);
    chk_rd("R4 controller read", pat(10'h026));
  endtask

  task automatic t_interleave();
    logic [AW-1:0] seq [4] = '{10'h040, 10'h043, 10'h042, 10'h041};
    order_il = 1'b1;
    cpu_read(10'h041);
    chk_rd("R2 processor start", pat(10'h041));
    for (int k = 0; k < 4; k++) begin
      adv_n = 1'b0; tick();
      chk_rd("R7 xor order", pat(seq[k]));
    end
    idle();
  endtask

  task automatic t_linear();
    logic [AW-1:0] seq [4] = '{10'h046, 10'h047, 10'h044, 10'h045};
    order_il = 1'b0;
    cpu_read(10'h045);
    for (int k = 0; k < 4; k++) begin
      adv_n = 1'b0; tick();
      chk_rd("R8 linear order", pat(seq[k]));
    end
    adv_n = 1'b1; tick();
    chk_rd("R6 suspend", pat(10'h045));
    order_il = 1'b1;
    idle();
  endtask

  task automatic t_lanes();
    idle(); ctl_stb_n = 1'b0; addr_i = 10'h020; wr_byte_n = 1'b0; lane_n = 2'b10; din = 18'h3FFFF;
    tick(); idle();
    chk_en("R11 byte write edge", 1'b0);
    ctl_read(10'h020);
    chk_rd("R10 lane0 only", {pat(10'h020)[17:9], 9'h1FF});
    idle(); ctl_stb_n = 1'b0; addr_i = 10'h024; wr_byte_n = 1'b0; lane_n = 2'b01; din = 18'h0;
    tick(); idle();
    ctl_read(10'h024);
    chk_rd("R10 lane1 only", {9'h000, pat(10'h024)[8:0]});
    idle(); ctl_stb_n = 1'b0; addr_i = 10'h025; wr_byte_n = 1'b1; lane_n = 2'b00; din = 18'h0;
    tick(); idle();
    chk_rd("R10 byte enable high reads", pat(10'h025));
    idle(); ctl_stb_n = 1'b0; addr_i = 10'h021; wr_all_n = 1'b0; lane_n = 2'b11; din = 18'h12345;
    tick(); idle();
    ctl_read(10'h021);
    chk_rd("R9 global write", 18'h12345);
  endtask

  task automatic t_continue_write();
    order_il = 1'b1;
    idle(); cpu_stb_n = 1'b0; addr_i = 10'h022; wr_all_n = 1'b0; din = 18'h0BEEF;
    tick();
    chk_rd("R2 write ignored on processor start", pat(10'h022));
    idle(); adv_n = 1'b0; wr_all_n = 1'b0; din = 18'h2AAAA;
    tick();
    chk_en("R11 continuation write", 1'b0);
    idle();
    tick();
    chk_rd("R6 write landed on next burst address", 18'h2AAAA);
    oe_n = 1'b1; #1;
    chk_en("R12 oe high", 1'b0);
    oe_n = 1'b0; #1;
    chk_en("R12 oe low async", 1'b1);
    ctl_read(10'h022);
    chk_rd("R2 start word unchanged", pat(10'h022));
  endtask

  task automatic t_enables();
    cpu_read(10'h023);
    idle(); cpu_stb_n = 1'b0; en_main_n = 1'b1; addr_i = 10'h047;
    tick(); idle();
    chk_rd("R3 main enable blocks processor strobe", 18'h2AAAA);
    idle(); ctl_stb_n = 1'b0; en_main_n = 1'b1; addr_i = 10'h040;
    tick(); idle();
    chk_en("R5 controller deselect", 1'b0);
    for (int k = 0; k < 3; k++) begin
      adv_n = 1'b0; tick();
      chk_en("R5 advance after deselect", 1'b0);
    end
    idle();
    cpu_read(10'h040);
    chk_rd("R2 reload after deselect", pat(10'h040));
    idle(); cpu_stb_n = 1'b0; en_high = 1'b0; addr_i = 10'h041;
    tick(); idle();
    chk_en("R5 processor deselect", 1'b0);
  endtask

  initial begin
    rst = 1'b1; oe_n = 1'b0; order_il = 1'b1; addr_i = '0; din = '0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    t_reset();
    t_prefill();
    t_interleave();
    t_linear();
    t_lanes();
    t_continue_write();
    t_enables();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule